// File: doc/BRIEF.md
# Global-History XOR-Indexed Branch Direction Predictor

This block guesses, at fetch time, whether a conditional branch will be taken. A lookup port takes the fetch address. One cycle later it returns a taken/not-taken guess, together with the branch-outcome history that was used to form it. The pipeline carries that history snapshot with the branch. When the branch resolves, the pipeline sends the branch address, the snapshot and the real outcome back on the update port.

Inside, a table of two-bit saturating counters is addressed by the word-aligned fetch address XORed with a register that holds recent branch outcomes. Branches that arrive along the same recent path can therefore share trained state. Each update moves one counter one step toward the real outcome and shifts that outcome into the history register.

After reset the block sweeps the table once to set every counter to its weak not-taken value, and it reports `ready` when the sweep is done. The table is written so that an FPGA tool can map it to block RAM.

Top module: `gshare_pred`

## Requirements
- R1: After `rst` is released, `ready` stays low for exactly 2^IDX_W clock cycles and then rises. From then on, every table entry predicts not-taken and the history register reads zero.
- R2: Each accepted update shifts the history register left by one place and inserts the real outcome at bit 0 (1 = taken). Without an accepted update the history register holds its value.
- R3: A taken update adds one to the addressed counter, and a counter that already holds 3 stays at 3.
- R4: A not-taken update subtracts one from the addressed counter, and a counter that already holds 0 stays at 0.
- R5: The guess is bit 1 of the addressed counter (1 = taken). Counters start at 01, so a single taken update on a fresh entry makes that entry predict taken.
- R6: The table address is PC[OFF+IDX_W-1:OFF] XOR the history, with the history zero-extended at the high end. PC bits below OFF do not affect the address.
- R7: An update addresses the table with the history snapshot it carries on `upd_hist`, not with the current value of the history register.
- R8: `pred_taken` and `pred_hist` are registered and belong to the lookup of the previous cycle. A lookup sees every update presented in earlier cycles. A lookup that meets an update to the same entry in the same cycle sees the value before that update.
- R9: Updates presented while `ready` is low change neither the table nor the history register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | Fetch address to look up |
| pred_taken | output | 1 | Guess for the previous cycle's lookup |
| pred_hist | output | HIST_W | History used for that guess |
| upd_valid | input | 1 | A resolved branch is presented |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_hist | input | HIST_W | History snapshot returned with the branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |
| ready | output | 1 | Reset sweep finished |

## Verification
A guess is due exactly one clock edge after its lookup is presented, so the bench samples one time unit after that edge. It compares against a reference model whose state holds every update presented before that cycle, and it applies the current cycle's update to the model only after the comparison. This keeps the same-cycle rule and the back-to-back-update rule in the expected values without any extra timing slack. `ready` is checked on the edge on which the sweep should end and on the edge before it. The history snapshot is compared on the same edge as the guess.

// File: rtl/gshare_pkg.sv
package gshare_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_WEAK_NT = 2'b01;

  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'b01;
    else       return (c == 2'b00) ? c : c - 2'b01;
  endfunction
endpackage

// File: rtl/gshare_index.sv
module gshare_index #(
  parameter int IDX_W  = 11,
  parameter int HIST_W = 8
) (
  input  logic [IDX_W-1:0]  pc_bits,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  assign idx = pc_bits ^ IDX_W'(hist);
endmodule

// File: rtl/gshare_ghr.sv
module gshare_ghr #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)           hist <= '0;
    else if (shift_en) hist <= {hist[HIST_W-2:0], bit_in};
  end
endmodule

// File: rtl/gshare_pht.sv
module gshare_pht #(
  parameter int AW = 11
) (
  input  logic                   clk,
  input  logic [AW-1:0]          ra_addr,
  output gshare_pkg::ctr_t       ra_data,
  input  logic [AW-1:0]          rb_addr,
  output gshare_pkg::ctr_t       rb_data,
  input  logic                   we,
  input  logic [AW-1:0]          wa,
  input  gshare_pkg::ctr_t       wd
);
  localparam int DEPTH = 1 << AW;
  gshare_pkg::ctr_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    ra_data <= mem[ra_addr];
    rb_data <= mem[rb_addr];
  end
endmodule

// File: rtl/gshare_pred.sv
module gshare_pred #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 11,
  parameter int HIST_W = 8,
  parameter int OFF    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic [HIST_W-1:0] upd_hist,
  input  logic              upd_taken,
  output logic              ready
);
  import gshare_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = '1;

  logic [HIST_W-1:0] ghr;
  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic              init_busy;
  logic [IDX_W-1:0]  init_cnt;
  logic              upd_ok;

  logic              u1_valid, u1_taken, u1_fwd;
  logic [IDX_W-1:0]  u1_idx;
  ctr_t              u1_fwd_val;
  ctr_t              cur, wr_data, ra_data, rb_data;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;

  logic              lk_busy_q, lk_byp, lk_byp_bit;

  logic              mem_we;
  logic [IDX_W-1:0]  mem_wa;
  ctr_t              mem_wd;

  logic unused_ok;
  assign unused_ok = ^{lk_pc, upd_pc};

  gshare_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_lk_index (
    .pc_bits(lk_pc[OFF +: IDX_W]), .hist(ghr), .idx(lk_idx));

  gshare_index #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_up_index (
    .pc_bits(upd_pc[OFF +: IDX_W]), .hist(upd_hist), .idx(up_idx));

  assign upd_ok = upd_valid & ~init_busy;

  gshare_ghr #(.HIST_W(HIST_W)) u_ghr (
    .clk(clk), .rst(rst), .shift_en(upd_ok), .bit_in(upd_taken), .hist(ghr));

  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_cnt  <= '0;
    end else if (init_busy) begin
      init_cnt <= init_cnt + 1'b1;
      if (init_cnt == LAST_IDX) init_busy <= 1'b0;
    end
  end
  assign ready = ~init_busy;

  // Update stage 1: read the counter; forward a write that lands on the same entry.
  always_ff @(posedge clk) begin
    if (rst) begin
      u1_valid   <= 1'b0;
      u1_taken   <= 1'b0;
      u1_idx     <= '0;
      u1_fwd     <= 1'b0;
      u1_fwd_val <= CTR_WEAK_NT;
    end else begin
      u1_valid   <= upd_ok;
      u1_taken   <= upd_taken;
      u1_idx     <= up_idx;
      u1_fwd     <= wr_en && (wr_idx == up_idx);
      u1_fwd_val <= wr_data;
    end
  end

  // Update stage 2: step the counter and write it back.
  assign cur     = u1_fwd ? u1_fwd_val : rb_data;
  assign wr_data = ctr_step(cur, u1_taken);
  assign wr_en   = u1_valid;
  assign wr_idx  = u1_idx;

  assign mem_we = init_busy | wr_en;
  assign mem_wa = init_busy ? init_cnt : wr_idx;
  assign mem_wd = init_busy ? CTR_WEAK_NT : wr_data;

  gshare_pht #(.AW(IDX_W)) u_pht (
    .clk(clk), .ra_addr(lk_idx), .ra_data(ra_data),
    .rb_addr(up_idx), .rb_data(rb_data),
    .we(mem_we), .wa(mem_wa), .wd(mem_wd));

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_busy_q  <= 1'b1;
      lk_byp     <= 1'b0;
      lk_byp_bit <= 1'b0;
      pred_hist  <= '0;
    end else begin
      lk_busy_q  <= init_busy;
      lk_byp     <= wr_en && (wr_idx == lk_idx);
      lk_byp_bit <= wr_data[1];
      pred_hist  <= ghr;
    end
  end

  assign pred_taken = lk_busy_q ? 1'b0 : (lk_byp ? lk_byp_bit : ra_data[1]);
endmodule

// File: rtl/gshare_pred_chk.sv
module gshare_pred_chk #(
  parameter int HIST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_valid,
  input logic              upd_taken,
  input logic              ready,
  input logic [HIST_W-1:0] ghr,
  input logic [HIST_W-1:0] pred_hist,
  input logic              pred_taken,
  input logic              wr_en,
  input logic [1:0]        cur_ctr,
  input logic [1:0]        wr_ctr,
  input logic              upd_in
);
  // R2
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && ready) |=> ghr == {$past(ghr[HIST_W-2:0]), $past(upd_taken)});
  // R2
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(upd_valid && ready) |=> $stable(ghr));
  // R9
  init_hist_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> ghr == '0);
  // R1
  init_pred_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |=> !pred_taken);
  // R8
  snap_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pred_hist == $past(ghr));
  // R3
  sat_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && upd_in && cur_ctr == 2'b11) |-> wr_ctr == 2'b11);
  // R3
  inc_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && upd_in && cur_ctr != 2'b11) |-> wr_ctr == cur_ctr + 2'b01);
  // R4
  sat_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !upd_in && cur_ctr == 2'b00) |-> wr_ctr == 2'b00);
  // R4
  dec_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !upd_in && cur_ctr != 2'b00) |-> wr_ctr == cur_ctr - 2'b01);
endmodule

bind gshare_pred gshare_pred_chk #(.HIST_W(HIST_W)) u_chk (
  .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_taken(upd_taken),
  .ready(ready), .ghr(ghr), .pred_hist(pred_hist), .pred_taken(pred_taken),
  .wr_en(wr_en), .cur_ctr(cur), .wr_ctr(wr_data), .upd_in(u1_taken));

// File: tb/gshare_pred_test.sv
`timescale 1ns/1ps
module gshare_pred_test;
  localparam int PC_W = 12, IDX_W = 4, HIST_W = 3, OFF = 2;
  localparam int N = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] lk_pc = '0, upd_pc = '0;
  logic [HIST_W-1:0] upd_hist = '0, pred_hist;
  logic upd_valid = 1'b0, upd_taken = 1'b0, pred_taken, ready;

  always #4 clk = ~clk;

  gshare_pred #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W), .OFF(OFF)) uut (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_hist(upd_hist), .upd_taken(upd_taken), .ready(ready));

  int tests = 0, fails = 0;
  int model [N];
  logic [HIST_W-1:0] mghr;
  bit done = 0;

  function automatic int idx_of(logic [PC_W-1:0] pc, logic [HIST_W-1:0] h);
    return int'((pc >> OFF) & (N - 1)) ^ int'(h);
  endfunction

  // PC whose lookup addresses entry e under history h, with the given offset bits
  function automatic logic [PC_W-1:0] pc_for(int e, logic [HIST_W-1:0] h, int lo);
    return PC_W'(((e ^ int'(h)) << OFF) | (lo & ((1 << OFF) - 1)));
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One cycle: drive inputs, check the registered outputs after the edge, then train the model.
  task automatic cyc(string req, logic [PC_W-1:0] lpc, logic uv,
                     logic [PC_W-1:0] upc, logic [HIST_W-1:0] uh, logic ut);
    int exp_p, exp_h, e;
    lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_hist = uh; upd_taken = ut;
    exp_p = (model[idx_of(lpc, mghr)] >> 1) & 1;
    exp_h = int'(mghr);
    @(posedge clk); #1;
    check({req, " pred"}, int'(pred_taken), exp_p);
    check({req, " hist"}, int'(pred_hist), exp_h);
    if (uv) begin
      e = idx_of(upc, uh);
      if (ut) model[e] = (model[e] == 3) ? 3 : model[e] + 1;
      else    model[e] = (model[e] == 0) ? 0 : model[e] - 1;
      mghr = {mghr[HIST_W-2:0], ut};
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = 1;
    mghr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: updates during the sweep are ignored
    upd_valid = 1'b1; upd_taken = 1'b1; upd_pc = pc_for(3, 0, 0);
    for (int c = 1; c <= N; c++) begin
      @(posedge clk); #1;
      if (c == N - 1) check("R1 ready low before sweep end", int'(ready), 0);
      if (c == N)     check("R1 ready after sweep", int'(ready), 1);
    end
    @(negedge clk);
    upd_valid = 1'b0;
    // R1 / R9: every entry weak not-taken, history zero
    for (int e = 0; e < N; e++) cyc("R1 R9 clean table", pc_for(e, 0, e), 0, 0, 0, 0);

    // R3 / R5: train entry 5 taken past saturation, via snapshot hist 3 (R7)
    for (int k = 0; k < 5; k++) begin
      cyc("R3 R5 R7 taken", pc_for(5, mghr, k), 1, pc_for(5, 3'd3, 1), 3'd3, 1);
      cyc("R3 R5 probe", pc_for(5, mghr, 2), 0, 0, 0, 0);
    end
    // R4: drive entry 5 down past zero, then one taken step
    for (int k = 0; k < 5; k++) begin
      cyc("R4 not-taken", pc_for(5, mghr, 3), 1, pc_for(5, 3'd3, 0), 3'd3, 0);
      cyc("R4 probe", pc_for(5, mghr, 1), 0, 0, 0, 0);
    end
    cyc("R4 R5 from zero", pc_for(5, mghr, 0), 1, pc_for(5, 3'd3, 0), 3'd3, 1);
    cyc("R4 R5 probe", pc_for(5, mghr, 0), 0, 0, 0, 0);

    // R8: same-cycle lookup and update on one entry, then back-to-back updates
    cyc("R8 same cycle", pc_for(9, mghr, 0), 1, pc_for(9, 3'd6, 0), 3'd6, 1);
    cyc("R8 next cycle", pc_for(9, mghr, 0), 1, pc_for(9, 3'd6, 0), 3'd6, 1);
    cyc("R8 back to back", pc_for(9, mghr, 0), 1, pc_for(9, 3'd6, 0), 3'd6, 0);
    cyc("R8 after", pc_for(9, mghr, 0), 0, 0, 0, 0);

    // R2 / R6: history pattern walk with all offset bits
    for (int k = 0; k < 16; k++)
      cyc("R2 R6 walk", PC_W'(k * 5), 1, PC_W'(k * 7), 3'(k), k[0] ^ k[2]);

    // R6 R7 R8: mixed random traffic
    for (int k = 0; k < 4000; k++)
      cyc("R6 R7 R8 random", PC_W'($urandom), 1'($urandom), PC_W'($urandom),
          ($urandom % 4 == 0) ? mghr : HIST_W'($urandom), 1'($urandom));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule